// File: doc/BRIEF.md
# Private-Mode Memory Latency Estimator

This block runs beside a shared memory bus and estimates how long one CPU's memory requests would take if that CPU had the bus to itself. It keeps a short queue of the CPU's requests in the order they arrived. Each request holds a bank number and a row (page) number. The block does not look at the contended shared queue. Instead it replays the queued requests against its own copy of the row that each bank would have open under private execution.

Each emulation step selects one queued request. A row-buffer scheduler prefers the oldest request whose row is already open in its bank; if there is none, it takes the oldest request. The step charges that request a row-hit or row-conflict latency, both of which software can program. The request's estimated queue latency is the running sum of the service latencies of every request emulated since the queue was last empty, its own included. Two cumulative outputs, a latency sum and a request count, let a consumer form the average private-mode latency. An enable input paces the emulation so the host can decide when requests are drained.

Top module: `priv_lat_est`

## Requirements
- R1: The queue holds up to DEPTH (8) requests. `full` is 1 exactly when 8 requests are held, and a request offered while `full` is 1 is dropped: it is never emulated and never counted.
- R2: Each emulated request reports its own bank and row on `done_bank` and `done_page`, one cycle after the clock edge that selects it.
- R3: After reset no bank has an open row, so the first request to any bank is a row conflict (`done_hit` = 0).
- R4: A request is a row hit (`done_hit` = 1) when its bank's emulated open row equals its row. A hit is charged `hit_lat`; anything else is charged `conf_lat`. Both values are sampled at the selecting edge.
- R5: Among the queued requests, the oldest row-hit request is emulated first. If no queued request hits, the oldest request in arrival order is emulated.
- R6: After a request is emulated, its bank's open row becomes that request's row.
- R7: `done_est` equals the sum of the charged latencies of all requests emulated since the queue was last empty, including this one. The sum saturates at all ones. The sum restarts when an emulation leaves the queue empty.
- R8: Each emulation adds `done_est` to `lat_sum` and 1 to `req_count`. Neither output changes in any other cycle.
- R9: While `emu_en` is 0, nothing is emulated and `done_valid` stays 0. While it is 1 and the queue is not empty, one request is emulated per clock.
- R10: While reset is asserted, `full`, `done_valid`, `lat_sum` and `req_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | A request is offered this cycle |
| in_bank | input | BANK_W (3) | Bank of the offered request |
| in_page | input | PAGE_W (12) | Row of the offered request |
| emu_en | input | 1 | Allows one emulation step per cycle |
| hit_lat | input | LAT_W (8) | Latency charged for a row hit |
| conf_lat | input | LAT_W (8) | Latency charged for a row conflict |
| full | output | 1 | The queue holds DEPTH requests |
| done_valid | output | 1 | A request was emulated at the last edge |
| done_hit | output | 1 | That request was a row hit |
| done_bank | output | BANK_W (3) | Bank of that request |
| done_page | output | PAGE_W (12) | Row of that request |
| done_est | output | EST_W (16) | Estimated queue latency of that request |
| lat_sum | output | SUM_W (32) | Cumulative sum of estimates |
| req_count | output | CNT_W (32) | Number of requests emulated |

## Verification
The properties assume that `hit_lat` and `conf_lat` never exceed the saturation value of `done_est`, and that `emu_en`, `in_valid` and the latency inputs hold defined values from the first clock onward. The bench drives every input from time zero. It keeps both latencies well under 256. It changes the latency inputs only between scenarios, while the queue is empty. The bench also never offers so many requests that `lat_sum` or `req_count` could wrap.

// File: rtl/lpe_pkg.sv
package lpe_pkg;
  localparam int DEF_DEPTH  = 8;
  localparam int DEF_BANK_W = 3;
  localparam int DEF_PAGE_W = 12;
  localparam int DEF_LAT_W  = 8;
  localparam int DEF_EST_W  = 16;
  localparam int DEF_SUM_W  = 32;
  localparam int DEF_CNT_W  = 32;

  typedef enum logic {
    SVC_CONFLICT = 1'b0,
    SVC_ROWHIT   = 1'b1
  } svc_kind_e;
endpackage

// File: rtl/lpe_req_queue.sv
module lpe_req_queue #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 3,
  parameter int PAGE_W = 12,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int QCW   = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push_valid,
  input  logic [BANK_W-1:0]             push_bank,
  input  logic [PAGE_W-1:0]             push_page,
  input  logic                          pop,
  input  logic [IDX_W-1:0]              pop_idx,
  output logic [DEPTH-1:0]              ent_valid,
  output logic [DEPTH-1:0][BANK_W-1:0]  ent_bank,
  output logic [DEPTH-1:0][PAGE_W-1:0]  ent_page,
  output logic [QCW-1:0]                count,
  output logic                          full,
  output logic                          push_ok
);
  logic [DEPTH-1:0]             valid_q, valid_d;
  logic [DEPTH-1:0][BANK_W-1:0] bank_q, bank_d;
  logic [DEPTH-1:0][PAGE_W-1:0] page_q, page_d;
  logic [QCW-1:0]               count_q, count_d, cnt_after;
  logic                         q_en;

  assign full    = (count_q == QCW'(DEPTH));
  assign push_ok = push_valid && !full;
  assign q_en    = push_ok || pop;

  // index 0 always holds the oldest entry; removal collapses the entries above
  always_comb begin
    valid_d   = valid_q;
    bank_d    = bank_q;
    page_d    = page_q;
    cnt_after = count_q;
    if (pop) begin
      cnt_after = count_q - 1'b1;
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (i >= int'(pop_idx)) begin
          valid_d[i] = valid_q[i+1];
          bank_d[i]  = bank_q[i+1];
          page_d[i]  = page_q[i+1];
        end
      end
      valid_d[DEPTH-1] = 1'b0;
      bank_d[DEPTH-1]  = '0;
      page_d[DEPTH-1]  = '0;
    end
    count_d = cnt_after;
    if (push_ok) begin
      valid_d[cnt_after[IDX_W-1:0]] = 1'b1;
      bank_d[cnt_after[IDX_W-1:0]]  = push_bank;
      page_d[cnt_after[IDX_W-1:0]]  = push_page;
      count_d = cnt_after + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      bank_q  <= '0;
      page_q  <= '0;
      count_q <= '0;
    end else if (q_en) begin
      valid_q <= valid_d;
      bank_q  <= bank_d;
      page_q  <= page_d;
      count_q <= count_d;
    end
  end

  assign ent_valid = valid_q;
  assign ent_bank  = bank_q;
  assign ent_page  = page_q;
  assign count     = count_q;
endmodule

// File: rtl/lpe_open_rows.sv
module lpe_open_rows #(
  parameter int BANK_W = 3,
  parameter int PAGE_W = 12,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         upd,
  input  logic [BANK_W-1:0]            upd_bank,
  input  logic [PAGE_W-1:0]            upd_page,
  output logic [NBANK-1:0]             open_vld,
  output logic [NBANK-1:0][PAGE_W-1:0] open_page
);
  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic bank_en;
    assign bank_en = upd && (upd_bank == BANK_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_vld[g]  <= 1'b0;
        open_page[g] <= '0;
      end else if (bank_en) begin
        open_vld[g]  <= 1'b1;
        open_page[g] <= upd_page;
      end
    end
  end
endmodule

// File: rtl/lpe_pick.sv
module lpe_pick #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 3,
  parameter int PAGE_W = 12,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic [DEPTH-1:0]             ent_valid,
  input  logic [DEPTH-1:0][BANK_W-1:0] ent_bank,
  input  logic [DEPTH-1:0][PAGE_W-1:0] ent_page,
  input  logic [NBANK-1:0]             open_vld,
  input  logic [NBANK-1:0][PAGE_W-1:0] open_page,
  output logic [IDX_W-1:0]             sel_idx,
  output lpe_pkg::svc_kind_e           sel_kind
);
  logic [DEPTH-1:0] row_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign row_hit[g] = ent_valid[g] && open_vld[ent_bank[g]] &&
                        (open_page[ent_bank[g]] == ent_page[g]);
  end

  // scan from youngest to oldest so the lowest hitting index wins
  always_comb begin
    sel_idx  = '0;
    sel_kind = lpe_pkg::SVC_CONFLICT;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (row_hit[i]) begin
        sel_idx  = IDX_W'(i);
        sel_kind = lpe_pkg::SVC_ROWHIT;
      end
    end
  end
endmodule

// File: rtl/priv_lat_est.sv
module priv_lat_est #(
  parameter int DEPTH  = lpe_pkg::DEF_DEPTH,
  parameter int BANK_W = lpe_pkg::DEF_BANK_W,
  parameter int PAGE_W = lpe_pkg::DEF_PAGE_W,
  parameter int LAT_W  = lpe_pkg::DEF_LAT_W,
  parameter int EST_W  = lpe_pkg::DEF_EST_W,
  parameter int SUM_W  = lpe_pkg::DEF_SUM_W,
  parameter int CNT_W  = lpe_pkg::DEF_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [PAGE_W-1:0] in_page,
  input  logic              emu_en,
  input  logic [LAT_W-1:0]  hit_lat,
  input  logic [LAT_W-1:0]  conf_lat,
  output logic              full,
  output logic              done_valid,
  output logic              done_hit,
  output logic [BANK_W-1:0] done_bank,
  output logic [PAGE_W-1:0] done_page,
  output logic [EST_W-1:0]  done_est,
  output logic [SUM_W-1:0]  lat_sum,
  output logic [CNT_W-1:0]  req_count
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int QCW   = $clog2(DEPTH + 1);
  localparam int NBANK = 1 << BANK_W;

  logic [DEPTH-1:0]             ent_valid;
  logic [DEPTH-1:0][BANK_W-1:0] ent_bank;
  logic [DEPTH-1:0][PAGE_W-1:0] ent_page;
  logic [QCW-1:0]               q_count;
  logic                         push_ok;
  logic [NBANK-1:0]             open_vld;
  logic [NBANK-1:0][PAGE_W-1:0] open_page;
  logic [IDX_W-1:0]             sel_idx;
  lpe_pkg::svc_kind_e           sel_kind;

  logic              pick;
  logic [LAT_W-1:0]  svc_lat;
  logic [EST_W:0]    sum_ext;
  logic [EST_W-1:0]  est_now;
  logic              drain;
  logic [BANK_W-1:0] pick_bank;
  logic [PAGE_W-1:0] pick_page;

  logic [EST_W-1:0]  acc_q, acc_d;
  logic              dv_d, dh_d;
  logic [BANK_W-1:0] db_q, db_d;
  logic [PAGE_W-1:0] dp_q, dp_d;
  logic [EST_W-1:0]  de_q, de_d;
  logic [SUM_W-1:0]  sum_q, sum_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              dv_q, dh_q;

  lpe_req_queue #(.DEPTH(DEPTH), .BANK_W(BANK_W), .PAGE_W(PAGE_W)) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (in_valid),
    .push_bank  (in_bank),
    .push_page  (in_page),
    .pop        (pick),
    .pop_idx    (sel_idx),
    .ent_valid  (ent_valid),
    .ent_bank   (ent_bank),
    .ent_page   (ent_page),
    .count      (q_count),
    .full       (full),
    .push_ok    (push_ok)
  );

  lpe_pick #(.DEPTH(DEPTH), .BANK_W(BANK_W), .PAGE_W(PAGE_W)) u_pick (
    .ent_valid (ent_valid),
    .ent_bank  (ent_bank),
    .ent_page  (ent_page),
    .open_vld  (open_vld),
    .open_page (open_page),
    .sel_idx   (sel_idx),
    .sel_kind  (sel_kind)
  );

  lpe_open_rows #(.BANK_W(BANK_W), .PAGE_W(PAGE_W)) u_rows (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd       (pick),
    .upd_bank  (pick_bank),
    .upd_page  (pick_page),
    .open_vld  (open_vld),
    .open_page (open_page)
  );

  assign pick      = emu_en && ent_valid[0];
  assign pick_bank = ent_bank[sel_idx];
  assign pick_page = ent_page[sel_idx];
  assign svc_lat   = (sel_kind == lpe_pkg::SVC_ROWHIT) ? hit_lat : conf_lat;
  assign sum_ext   = {1'b0, acc_q} + {{(EST_W + 1 - LAT_W){1'b0}}, svc_lat};
  assign est_now   = sum_ext[EST_W] ? {EST_W{1'b1}} : sum_ext[EST_W-1:0];
  assign drain     = (q_count == QCW'(1)) && !push_ok;

  // next-state for the busy-period accumulator and the reported results
  always_comb begin
    acc_d = acc_q;
    dv_d  = pick;
    dh_d  = dh_q;
    db_d  = db_q;
    dp_d  = dp_q;
    de_d  = de_q;
    sum_d = sum_q;
    cnt_d = cnt_q;
    if (pick) begin
      acc_d = drain ? '0 : est_now;
      dh_d  = (sel_kind == lpe_pkg::SVC_ROWHIT);
      db_d  = pick_bank;
      dp_d  = pick_page;
      de_d  = est_now;
      sum_d = sum_q + {{(SUM_W - EST_W){1'b0}}, est_now};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q <= 1'b0;
    end else begin
      dv_q <= dv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      dh_q  <= 1'b0;
      db_q  <= '0;
      dp_q  <= '0;
      de_q  <= '0;
      sum_q <= '0;
      cnt_q <= '0;
    end else if (pick) begin
      acc_q <= acc_d;
      dh_q  <= dh_d;
      db_q  <= db_d;
      dp_q  <= dp_d;
      de_q  <= de_d;
      sum_q <= sum_d;
      cnt_q <= cnt_d;
    end
  end

  assign done_valid = dv_q;
  assign done_hit   = dh_q;
  assign done_bank  = db_q;
  assign done_page  = dp_q;
  assign done_est   = de_q;
  assign lat_sum    = sum_q;
  assign req_count  = cnt_q;
endmodule

// File: rtl/lpe_checker.sv
module lpe_checker #(
  parameter int LAT_W = 8,
  parameter int EST_W = 16,
  parameter int SUM_W = 32,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             emu_en,
  input logic [LAT_W-1:0] hit_lat,
  input logic [LAT_W-1:0] conf_lat,
  input logic             done_valid,
  input logic             done_hit,
  input logic [EST_W-1:0] done_est,
  input logic [SUM_W-1:0] lat_sum,
  input logic [CNT_W-1:0] req_count
);
  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> req_count == $past(req_count) + 1'b1);

  // R8
  sum_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> lat_sum == $past(lat_sum) + {{(SUM_W - EST_W){1'b0}}, done_est});

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_valid |-> ($stable(lat_sum) && $stable(req_count)));

  // R9
  emu_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(emu_en) |-> !done_valid);

  // R7
  est_hit_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_hit) |-> done_est >= {{(EST_W - LAT_W){1'b0}}, $past(hit_lat)});

  // R7
  est_conf_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_hit) |-> done_est >= {{(EST_W - LAT_W){1'b0}}, $past(conf_lat)});
endmodule

bind priv_lat_est lpe_checker #(
  .LAT_W(LAT_W), .EST_W(EST_W), .SUM_W(SUM_W), .CNT_W(CNT_W)
) u_lpe_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .emu_en     (emu_en),
  .hit_lat    (hit_lat),
  .conf_lat   (conf_lat),
  .done_valid (done_valid),
  .done_hit   (done_hit),
  .done_est   (done_est),
  .lat_sum    (lat_sum),
  .req_count  (req_count)
);

// File: tb/tb_priv_lat_est.sv
`timescale 1ns/1ps
module tb_priv_lat_est;
  localparam int HALF = 10;

  logic        clk, rst_n, in_valid, emu_en, full;
  logic [2:0]  in_bank;
  logic [11:0] in_page;
  logic [7:0]  hit_lat, conf_lat;
  logic        done_valid, done_hit;
  logic [2:0]  done_bank;
  logic [11:0] done_page;
  logic [15:0] done_est;
  logic [31:0] lat_sum, req_count;

  int errors = 0, checks = 0;
  bit finished = 0;

  int          ev_n;
  logic [15:0] ev_est[16];
  logic        ev_hit[16];
  logic [2:0]  ev_bank[16];
  logic [11:0] ev_page[16];

  priv_lat_est dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bank(in_bank),
    .in_page(in_page), .emu_en(emu_en), .hit_lat(hit_lat), .conf_lat(conf_lat),
    .full(full), .done_valid(done_valid), .done_hit(done_hit),
    .done_bank(done_bank), .done_page(done_page), .done_est(done_est),
    .lat_sum(lat_sum), .req_count(req_count)
  );

  initial clk = 1'b0;
  always #HALF clk = ~clk;

  // sample results 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (rst_n && done_valid && ev_n < 16) begin
      ev_est[ev_n]  = done_est;
      ev_hit[ev_n]  = done_hit;
      ev_bank[ev_n] = done_bank;
      ev_page[ev_n] = done_page;
      ev_n = ev_n + 1;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic offer(input logic [2:0] b, input logic [11:0] p);
    @(negedge clk);
    in_valid = 1'b1; in_bank = b; in_page = p;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_events(input int n);
    for (int k = 0; k < 40 && ev_n < n; k++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 full after reset", full, 0);
    chk("R10 done_valid after reset", done_valid, 0);
    chk("R10 lat_sum after reset", lat_sum, 0);
    chk("R10 req_count after reset", req_count, 0);
  endtask

  task automatic t_first_and_hit();
    ev_n = 0;
    emu_en = 1'b1;
    offer(3'd2, 12'd5);
    wait_events(1);
    chk("R3 first access is conflict", ev_hit[0], 0);
    chk("R4 conflict charge", ev_est[0], 80);
    chk("R2 bank reported", ev_bank[0], 2);
    chk("R2 row reported", ev_page[0], 5);
    chk("R8 sum after one", lat_sum, 80);
    chk("R8 count after one", req_count, 1);
    ev_n = 0;
    offer(3'd2, 12'd5);
    wait_events(1);
    chk("R6 row kept open gives hit", ev_hit[0], 1);
    chk("R4 hit charge", ev_est[0], 40);
    chk("R8 sum after two", lat_sum, 120);
  endtask

  task automatic t_reorder();
    ev_n = 0;
    emu_en = 1'b0;
    offer(3'd2, 12'd9);
    offer(3'd2, 12'd5);
    offer(3'd3, 12'd1);
    @(negedge clk);
    emu_en = 1'b1;
    wait_events(3);
    chk("R5 hit served first row", ev_page[0], 5);
    chk("R5 hit served first est", ev_est[0], 40);
    chk("R5 then oldest row", ev_page[1], 9);
    chk("R7 accumulated second", ev_est[1], 120);
    chk("R6 bank2 reopened conflict", ev_hit[1], 0);
    chk("R5 last bank", ev_bank[2], 3);
    chk("R7 accumulated third", ev_est[2], 200);
    chk("R8 count after reorder", req_count, 5);
  endtask

  task automatic t_full();
    logic [31:0] sum0, cnt0;
    sum0 = lat_sum; cnt0 = req_count;
    ev_n = 0;
    emu_en = 1'b0;
    for (int k = 0; k < 8; k++) offer(3'd4, 12'd7);
    chk("R1 full at 8", full, 1);
    offer(3'd4, 12'd7);
    chk("R1 still full after drop", full, 1);
    emu_en = 1'b1;
    wait_events(9);
    chk("R1 only 8 emulated", ev_n, 8);
    chk("R1 count delta", req_count - cnt0, 8);
    chk("R3 fresh bank conflict", ev_hit[0], 0);
    chk("R9 one per cycle later hit", ev_hit[7], 1);
    chk("R7 last estimate", ev_est[7], 360);
    chk("R8 sum delta", lat_sum - sum0, 1760);
    chk("R1 not full after drain", full, 0);
  endtask

  task automatic t_program();
    @(negedge clk);
    hit_lat = 8'd10; conf_lat = 8'd25;
    ev_n = 0;
    offer(3'd6, 12'd100);
    wait_events(1);
    chk("R4 programmed conflict", ev_est[0], 25);
    ev_n = 0;
    offer(3'd6, 12'd100);
    wait_events(1);
    chk("R4 programmed hit", ev_est[0], 10);
    chk("R7 restart after empty", ev_hit[0], 1);
  endtask

  task automatic t_hold();
    logic [31:0] cnt0;
    cnt0 = req_count;
    ev_n = 0;
    emu_en = 1'b0;
    offer(3'd1, 12'd3);
    repeat (6) @(negedge clk);
    chk("R9 no emulation while disabled", ev_n, 0);
    chk("R9 count held while disabled", req_count, cnt0);
    emu_en = 1'b1;
    wait_events(1);
    chk("R9 resumes when enabled", ev_n, 1);
    chk("R4 held request conflict", ev_est[0], 25);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_bank = '0; in_page = '0;
    emu_en = 1'b0; hit_lat = 8'd40; conf_lat = 8'd80; ev_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_first_and_hit();
    t_reorder();
    t_full();
    t_program();
    t_hold();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule